// File: doc/BRIEF.md
# Dual-Setpoint Output Supervisor

This block supervises the output of a step-down regulator whose setpoint can be switched between two levels. It takes comparator flags that have already been digitized from the feedback node, a strobe that pulses once per switching cycle, a soft-start completion flag, an enable and an active-low power-on reset. From these it produces a power-good flag, an over-voltage latch that forces the low-side driver on, and an under-voltage latch that tristates both drivers. It also drives the control line of the divider pull-down switch, which follows the setpoint-select input.

The setpoint-select input is synchronized through two flops. Any edge on the synchronized value opens a blanking window that lasts a fixed number of switching cycles. While the window is open, power-good holds its value and the over-voltage trip point moves up from the +20% flag to the +50% flag. This lets the output slew to its new level without false faults. A new edge while the window is open starts the count again.

Top module: `vout_supervisor`

## Requirements
- R1: With enable high, soft-start done and no fault, `pgood` follows the window "neither `fb_lo20` nor `fb_hi20` set". It goes low when either flag is set and returns high once both are clear.
- R2: While `ss_done` is low, `pgood` is low. After `ss_done` rises, `pgood` may go high only through the normal qualification of R3.
- R3: A change of the power-good state takes effect only after the new condition has held for `QUAL_CLKS` consecutive clocks. An over-voltage condition must also hold for `QUAL_CLKS` consecutive clocks before it trips. A shorter pulse has no effect.
- R4: An edge of the synchronized select input freezes `pgood` at its present value for `BLANK_CYC` (default 32) strobes of `cyc_stb`. After that, `pgood` tracks the window again.
- R5: While the blanking window of R4 is open, the over-voltage condition is `fb_hi50` and `fb_hi20` is ignored. Once the window closes, the condition is `fb_hi20` again.
- R6: A qualified over-voltage sets `ovp_fault` and `low_force`. The latch holds until enable goes low or reset is applied, and `pgood` is low while it is set.
- R7: If `fb_lo30` is set on `UV_CYC` (default 8) consecutive strobes, `uvp_fault` and `drv_tristate` are set and `pgood` goes low. A strobe without `fb_lo30` restarts the count, and the latch holds until enable goes low or reset is applied.
- R8: `pulldown_on` is the inverse of the select input after a two-flop synchronizer: a low select turns the pull-down on and a high select turns it off. It follows the input two clock edges after the input changes.
- R9: Reset, or a low enable, clears both fault latches. During reset the outputs are `pgood`=0, `ovp_fault`=0, `uvp_fault`=0, `low_force`=0, `drv_tristate`=0 and `pulldown_on`=0.
- R10: A select edge that arrives while the blanking window is open reloads the window to the full `BLANK_CYC` strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| en | input | 1 | Enable; low clears faults and power-good |
| sel_in | input | 1 | Setpoint select, asynchronous |
| cyc_stb | input | 1 | One-clock pulse per switching cycle |
| ss_done | input | 1 | Soft-start complete |
| fb_lo20 | input | 1 | Feedback more than 20% below nominal |
| fb_lo30 | input | 1 | Feedback more than 30% below nominal |
| fb_hi20 | input | 1 | Feedback more than 20% above nominal |
| fb_hi50 | input | 1 | Feedback more than 50% above nominal |
| pgood | output | 1 | Power good |
| ovp_fault | output | 1 | Over-voltage latch |
| uvp_fault | output | 1 | Under-voltage latch |
| low_force | output | 1 | Force the low-side driver on |
| drv_tristate | output | 1 | Tristate both drivers |
| pulldown_on | output | 1 | Divider pull-down switch on |

## Verification
The hardest state to reach is the exact last strobe of the blanking window while an out-of-window condition is already present. The +20% flag has to be raised after the window is loaded, and the bench must then show that it is ignored through strobe 31 and trips just after strobe 32. To get there, the bench issues strobes one at a time from a task at a fixed four-clock spacing and checks between strobes. Restarting the window takes a second select edge part-way through the first window, followed by a count that would have expired under the first window but not under the reloaded one.

// File: rtl/vout_supervisor.sv
module vout_supervisor #(
  parameter int QUAL_CLKS = 625,
  parameter int BLANK_CYC = 32,
  parameter int UV_CYC    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sel_in,
  input  logic cyc_stb,
  input  logic ss_done,
  input  logic fb_lo20,
  input  logic fb_lo30,
  input  logic fb_hi20,
  input  logic fb_hi50,
  output logic pgood,
  output logic ovp_fault,
  output logic uvp_fault,
  output logic low_force,
  output logic drv_tristate,
  output logic pulldown_on
);
  localparam int QW = $clog2(QUAL_CLKS + 1);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int UW = $clog2(UV_CYC + 1);
  localparam logic [QW-1:0] QLAST = QW'(QUAL_CLKS - 1);
  localparam logic [UW-1:0] ULAST = UW'(UV_CYC - 1);

  logic [2:0]    sel_q;
  logic [BW-1:0] blank_cnt;
  logic [QW-1:0] ovp_cnt, pg_cnt;
  logic [UW-1:0] uv_cnt;
  logic          pg_reg;

  wire sel_edge  = sel_q[1] ^ sel_q[2];
  wire blanking  = blank_cnt != '0;
  wire ovp_raw   = blanking ? fb_hi50 : fb_hi20;
  wire window_ok = !fb_lo20 && !fb_hi20;
  wire ovp_set   = en && ovp_raw && !ovp_fault && !uvp_fault && ovp_cnt == QLAST;
  wire uvp_set   = en && cyc_stb && fb_lo30 && !uvp_fault && !ovp_fault && uv_cnt == ULAST;
  wire pg_block  = !en || !ss_done || ovp_fault || uvp_fault;

  assign pulldown_on  = ~sel_q[1];
  assign low_force    = ovp_fault;
  assign drv_tristate = uvp_fault;
  assign pgood        = pg_reg && !pg_block;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sel_q <= 3'b111;
    else        sel_q <= {sel_q[1:0], sel_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   blank_cnt <= '0;
    else if (sel_edge)            blank_cnt <= BW'(BLANK_CYC);
    else if (cyc_stb && blanking) blank_cnt <= blank_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovp_cnt   <= '0;
      ovp_fault <= 1'b0;
    end else begin
      if (!en || !ovp_raw || ovp_fault) ovp_cnt <= '0;
      else if (ovp_cnt != QLAST)        ovp_cnt <= ovp_cnt + 1'b1;
      if (!en)          ovp_fault <= 1'b0;
      else if (ovp_set) ovp_fault <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      uv_cnt    <= '0;
      uvp_fault <= 1'b0;
    end else begin
      if (!en || uvp_fault) uv_cnt <= '0;
      else if (cyc_stb)     uv_cnt <= !fb_lo30 ? '0 : (uv_cnt == ULAST ? uv_cnt : uv_cnt + 1'b1);
      if (!en)          uvp_fault <= 1'b0;
      else if (uvp_set) uvp_fault <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pg_reg <= 1'b0;
      pg_cnt <= '0;
    end else if (pg_block) begin
      pg_reg <= 1'b0;
      pg_cnt <= '0;
    end else if (blanking || window_ok == pg_reg) begin
      pg_cnt <= '0;
    end else if (pg_cnt == QLAST) begin
      pg_reg <= window_ok;
      pg_cnt <= '0;
    end else begin
      pg_cnt <= pg_cnt + 1'b1;
    end
endmodule

// File: rtl/vout_supervisor_chk.sv
module vout_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic ss_done,
  input logic fb_lo20,
  input logic fb_hi20,
  input logic pgood,
  input logic ovp_fault,
  input logic uvp_fault
);
  assert_ovp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_fault && en) |=> ovp_fault);
  assert_uvp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (uvp_fault && en) |=> uvp_fault);
  assert_fault_kills_pg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_fault || uvp_fault) |-> !pgood);
  assert_ss_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_done |-> !pgood);
  assert_pg_rise_in_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood) |-> $past(!fb_lo20 && !fb_hi20));
  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en) |-> (!ovp_fault && !uvp_fault));
endmodule

bind vout_supervisor vout_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .ss_done(ss_done),
  .fb_lo20(fb_lo20), .fb_hi20(fb_hi20), .pgood(pgood),
  .ovp_fault(ovp_fault), .uvp_fault(uvp_fault)
);

// File: tb/test_vout_supervisor.sv
module test_vout_supervisor;
  logic clk = 1'b0;
  logic rst_n, en, sel_in, cyc_stb, ss_done, fb_lo20, fb_lo30, fb_hi20, fb_hi50;
  logic pgood, ovp_fault, uvp_fault, low_force, drv_tristate, pulldown_on;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  vout_supervisor #(.QUAL_CLKS(4), .BLANK_CYC(32), .UV_CYC(8)) i_vout_supervisor (
    .clk(clk), .rst_n(rst_n), .en(en), .sel_in(sel_in), .cyc_stb(cyc_stb),
    .ss_done(ss_done), .fb_lo20(fb_lo20), .fb_lo30(fb_lo30), .fb_hi20(fb_hi20),
    .fb_hi50(fb_hi50), .pgood(pgood), .ovp_fault(ovp_fault), .uvp_fault(uvp_fault),
    .low_force(low_force), .drv_tristate(drv_tristate), .pulldown_on(pulldown_on)
  );

  // {lo20, ss_done, hold clocks[5:0], expected pgood}
  localparam logic [8:0] VEC [0:7] = '{
    {1'b0, 1'b0, 6'd6, 1'b0},
    {1'b0, 1'b1, 6'd6, 1'b1},
    {1'b1, 1'b1, 6'd6, 1'b0},
    {1'b0, 1'b1, 6'd6, 1'b1},
    {1'b1, 1'b1, 6'd2, 1'b1},
    {1'b0, 1'b1, 6'd6, 1'b1},
    {1'b0, 1'b0, 6'd1, 1'b0},
    {1'b0, 1'b1, 6'd6, 1'b1}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobes(input int n);
    for (int k = 0; k < n; k++) begin
      cyc_stb = 1'b1;
      @(negedge clk);
      cyc_stb = 1'b0;
      clocks(3);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; en = 0; sel_in = 1; cyc_stb = 0; ss_done = 0;
    fb_lo20 = 0; fb_lo30 = 0; fb_hi20 = 0; fb_hi50 = 0;
    clocks(3);
    chk("R9 reset pgood", pgood, 1'b0);
    chk("R9 reset ovp", ovp_fault, 1'b0);
    chk("R9 reset uvp", uvp_fault, 1'b0);
    chk("R9 reset low_force", low_force, 1'b0);
    chk("R9 reset tristate", drv_tristate, 1'b0);
    chk("R9 reset pulldown", pulldown_on, 1'b0);
    rst_n = 1; en = 1;
    clocks(1);

    // R1 R2 R3: window tracking, soft-start gate and glitch rejection
    for (int v = 0; v < 8; v++) begin
      fb_lo20 = VEC[v][8];
      ss_done = VEC[v][7];
      clocks(int'(VEC[v][6:1]));
      chk($sformatf("R1/R2/R3 vector %0d pgood", v), pgood, VEC[v][0]);
    end

    // R8: pull-down follows select after two edges
    sel_in = 0;
    clocks(1);
    chk("R8 pulldown one edge", pulldown_on, 1'b0);
    clocks(1);
    chk("R8 pulldown two edges", pulldown_on, 1'b1);
    clocks(2);

    // R4 R10: freeze and restart
    fb_lo20 = 1;
    clocks(10);
    chk("R4 frozen pgood", pgood, 1'b1);
    strobes(20);
    chk("R4 frozen after 20", pgood, 1'b1);
    sel_in = 1;
    clocks(4);
    chk("R8 pulldown release", pulldown_on, 1'b0);
    strobes(28);
    chk("R10 restart still frozen", pgood, 1'b1);
    strobes(4);
    clocks(6);
    chk("R4 tracking resumes", pgood, 1'b0);
    fb_lo20 = 0;
    clocks(6);
    chk("R1 back in window", pgood, 1'b1);

    // R5: raised threshold lasts exactly 32 strobes
    sel_in = 0;
    clocks(4);
    fb_hi20 = 1;
    strobes(31);
    chk("R5 hi20 ignored at 31", ovp_fault, 1'b0);
    chk("R4 pgood frozen with hi20", pgood, 1'b1);
    strobes(1);
    clocks(2);
    chk("R5 hi20 trips after 32", ovp_fault, 1'b1);
    chk("R6 low_force", low_force, 1'b1);
    chk("R6 pgood low on ovp", pgood, 1'b0);
    fb_hi20 = 0;
    clocks(10);
    chk("R6 ovp latched", ovp_fault, 1'b1);
    en = 0;
    clocks(2);
    chk("R9 enable clears ovp", ovp_fault, 1'b0);
    en = 1;
    clocks(6);
    chk("R1 pgood after re-enable", pgood, 1'b1);

    // R5: +50% still trips during blanking
    sel_in = 1;
    clocks(4);
    fb_hi20 = 1; fb_hi50 = 1;
    clocks(6);
    chk("R5 hi50 trips while blanking", ovp_fault, 1'b1);
    fb_hi20 = 0; fb_hi50 = 0;
    en = 0;
    clocks(2);
    en = 1;
    strobes(32);
    clocks(6);

    // R3: short over-voltage pulse ignored
    fb_hi20 = 1;
    clocks(3);
    fb_hi20 = 0;
    clocks(2);
    chk("R3 short ovp ignored", ovp_fault, 1'b0);

    // R7: eight consecutive low strobes
    fb_lo20 = 1; fb_lo30 = 1;
    strobes(7);
    chk("R7 seven strobes", uvp_fault, 1'b0);
    fb_lo30 = 0;
    strobes(1);
    fb_lo30 = 1;
    strobes(7);
    chk("R7 count restarted", uvp_fault, 1'b0);
    strobes(1);
    chk("R7 uvp set", uvp_fault, 1'b1);
    chk("R7 tristate", drv_tristate, 1'b1);
    chk("R7 pgood low", pgood, 1'b0);
    chk("R7 no low_force", low_force, 1'b0);
    fb_lo20 = 0; fb_lo30 = 0;
    clocks(5);
    chk("R7 uvp latched", uvp_fault, 1'b1);
    rst_n = 0;
    clocks(2);
    rst_n = 1;
    clocks(1);
    chk("R9 reset clears uvp", uvp_fault, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule